// File: doc/BRIEF.md
# Converter Power-Up and Control Sequencer

This controller brings an audio converter from reset to active playback. At power-on it holds the converter core (interpolation filters and modulators) in reset with every power enable off. Once both the master clock and the frame clock are reported present, it times one frame period so that the clock ratio can be measured. It then raises the voltage-reference enable. After a settle interval it releases the core reset and raises the converter, filter and output-ramp enables. Audio is unmuted only after a long run of valid-data frames, 2000 by default.

In parallel, a shared mode pin is sampled on each falling edge of the frame clock. Five consecutive samples at the same level switch de-emphasis: a low level turns it on and a high level turns it off. The pin carries this meaning only when the bit clock is generated internally. In external bit-clock mode it is a clock and is ignored. Loss of the master clock at any moment drops the block back to the power-down state. Analog settling is represented only by enables and cycle or frame counters.

Top module: `dac_bringup_ctrl`

## Requirements
- R1: After reset `core_rst` is 1 and `ref_en`, `conv_en`, `ramp_en`, `unmute` and `deemph_en` are all 0.
- R2: While `mclk_present` and `fclk_present` are not both 1, the block stays powered down with no enable raised.
- R3: With both clocks present, `ref_en` rises only at the second falling edge of `frm_clk` seen by the block, which completes one full frame period, and only if `ratio_valid` is 1 at that edge. Until then it waits.
- R4: `ref_en` rises first. `conv_en` and `ramp_en` rise, and `core_rst` falls, REF_SETTLE clock cycles later, with `ref_en` still high.
- R5: `unmute` rises on the clock after the UNMUTE_FRAMES-th (default 2000) falling edge of `frm_clk` counted with `data_valid` at 1 in the active state. When `data_valid` is 0 the count is cleared and `unmute` is 0 on the next cycle.
- R6: With `int_clk_mode` at 1, `deemph_en` becomes 1 after DEB_EDGES (default 5) consecutive `frm_clk` falling edges with `mode_pin` at 0. It becomes 0 after DEB_EDGES consecutive edges with `mode_pin` at 1. The change is visible on the clock after the last edge.
- R7: A `mode_pin` sample that differs from the previous sample restarts the consecutive-edge count at 1.
- R8: With `int_clk_mode` at 0, `deemph_en` is 0 on the next cycle and stays 0 whatever `mode_pin` does.
- R9: `mclk_present` at 0 returns the block to power-down on the next clock: `core_rst` 1 and all enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_present | input | 1 | Master clock detected |
| fclk_present | input | 1 | Frame clock detected |
| ratio_valid | input | 1 | Clock ratio measurement is valid |
| frm_clk | input | 1 | Frame clock level, synchronous to `clk` |
| mode_pin | input | 1 | Shared de-emphasis / bit-clock pin level |
| int_clk_mode | input | 1 | 1 = bit clock generated internally |
| data_valid | input | 1 | Serial audio data is valid |
| core_rst | output | 1 | Holds filters and modulators in reset |
| ref_en | output | 1 | Voltage reference enable |
| conv_en | output | 1 | Converter and switched-capacitor filter enable |
| ramp_en | output | 1 | Output ramp toward quiescent voltage enable |
| deemph_en | output | 1 | De-emphasis filter enable |
| unmute | output | 1 | Audio output unmute |

## Verification
The unmute counter and the de-emphasis debouncer both advance on the same frame-clock falling edge, so they can switch in the same cycle. The bench provokes this deliberately. It runs 1995 valid frames with the mode pin high, then 5 frames with the pin low, so that the 2000th data edge is also the fifth low sample. It checks that both outputs are still 0 after edge 1999 and that both are 1 after edge 2000. A fault in which one path stalls or steals the other's edge shows up as one output rising late or not at all.

// File: rtl/dac_bringup_ctrl.sv
module dac_bringup_ctrl #(
  parameter int UNMUTE_FRAMES = 2000,
  parameter int DEB_EDGES     = 5,
  parameter int REF_SETTLE    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_present,
  input  logic fclk_present,
  input  logic ratio_valid,
  input  logic frm_clk,
  input  logic mode_pin,
  input  logic int_clk_mode,
  input  logic data_valid,
  output logic core_rst,
  output logic ref_en,
  output logic conv_en,
  output logic ramp_en,
  output logic deemph_en,
  output logic unmute
);
  localparam int UW = $clog2(UNMUTE_FRAMES + 1);
  localparam int DW = $clog2(DEB_EDGES + 1);
  localparam int RW = $clog2(REF_SETTLE + 1);

  typedef enum logic [1:0] {S_OFF, S_MEAS, S_REF, S_RUN} state_t;

  state_t        state;
  logic          frm_q, seen, deb_lvl, deem_q;
  logic [UW-1:0] un_cnt;
  logic [DW-1:0] deb_cnt;
  logic [RW-1:0] ref_cnt;

  wire fall    = frm_q & ~frm_clk;
  wire deb_clr = ~mclk_present | (state == S_OFF) | ~int_clk_mode;

  assign core_rst  = (state != S_RUN);
  assign ref_en    = (state == S_REF) | (state == S_RUN);
  assign conv_en   = (state == S_RUN);
  assign ramp_en   = (state == S_RUN);
  assign unmute    = (state == S_RUN) & (un_cnt == UW'(UNMUTE_FRAMES));
  assign deemph_en = deem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      frm_q   <= 1'b0;
      seen    <= 1'b0;
      ref_cnt <= '0;
      un_cnt  <= '0;
    end else begin
      frm_q <= frm_clk;
      if (!mclk_present) begin
        state   <= S_OFF;
        seen    <= 1'b0;
        ref_cnt <= '0;
        un_cnt  <= '0;
      end else begin
        case (state)
          S_OFF: if (fclk_present) begin
            state <= S_MEAS;
            seen  <= 1'b0;
          end
          S_MEAS: if (fall) begin
            if (seen && ratio_valid) begin
              state   <= S_REF;
              ref_cnt <= '0;
            end
            seen <= 1'b1;
          end
          S_REF: begin
            ref_cnt <= ref_cnt + 1'b1;
            if (ref_cnt == RW'(REF_SETTLE - 1)) begin
              state  <= S_RUN;
              un_cnt <= '0;
            end
          end
          default: begin
            if (!data_valid) un_cnt <= '0;
            else if (fall && un_cnt != UW'(UNMUTE_FRAMES)) un_cnt <= un_cnt + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_cnt <= '0;
      deb_lvl <= 1'b0;
      deem_q  <= 1'b0;
    end else if (deb_clr) begin
      deb_cnt <= '0;
      deem_q  <= 1'b0;
    end else if (fall) begin
      if (deb_cnt == '0 || mode_pin != deb_lvl) begin
        deb_lvl <= mode_pin;
        deb_cnt <= DW'(1);
      end else if (deb_cnt != DW'(DEB_EDGES)) begin
        deb_cnt <= deb_cnt + 1'b1;
        if (deb_cnt == DW'(DEB_EDGES - 1)) deem_q <= ~mode_pin;
      end
    end
  end

  // R3
  ref_after_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(mclk_present && ratio_valid && fall));

  // R4
  conv_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_en) |-> $past(ref_en) && ref_en);

  // R5
  unmute_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unmute) |-> $past(data_valid && fall));

  // R6
  deemph_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deemph_en) |-> $past(fall && !mode_pin && int_clk_mode));

  // R8
  ext_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clk_mode |=> !deemph_en);

  // R9
  mclk_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_present |=> core_rst && !ref_en && !conv_en && !ramp_en && !unmute && !deemph_en);
endmodule

// File: tb/tb_dac_bringup_ctrl.sv
module tb_dac_bringup_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk_present = 0, fclk_present = 0, ratio_valid = 0, frm_clk = 0;
  logic mode_pin = 1, int_clk_mode = 0, data_valid = 0;
  logic core_rst, ref_en, conv_en, ramp_en, deemph_en, unmute;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dac_bringup_ctrl dut (.*);

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frames(int n, logic pin);
    for (int i = 0; i < n; i++) begin
      mode_pin = pin;
      frm_clk = 1'b1; clocks(4);
      frm_clk = 1'b0; clocks(4);
    end
  endtask

  task automatic t_reset;
    chk("R1 core_rst", core_rst, 1'b1);
    chk("R1 ref_en|conv_en|ramp_en", ref_en | conv_en | ramp_en, 1'b0);
    chk("R1 unmute|deemph_en", unmute | deemph_en, 1'b0);
  endtask

  task automatic t_wait_clocks;
    mclk_present = 1'b1;
    frames(3, 1'b1);
    chk("R2 ref_en with frame clock absent", ref_en, 1'b0);
    chk("R2 core_rst with frame clock absent", core_rst, 1'b1);
  endtask

  task automatic t_measure;
    fclk_present = 1'b1;
    clocks(2);
    frames(3, 1'b1);
    chk("R3 ref_en while ratio invalid", ref_en, 1'b0);
    ratio_valid = 1'b1;
    frames(1, 1'b1);
    chk("R3 ref_en after valid ratio edge", ref_en, 1'b1);
    chk("R4 conv_en before settle", conv_en, 1'b0);
    chk("R4 core_rst before settle", core_rst, 1'b1);
    clocks(20);
    chk("R4 conv_en after settle", conv_en, 1'b1);
    chk("R4 ramp_en after settle", ramp_en, 1'b1);
    chk("R4 core_rst released", core_rst, 1'b0);
    chk("R4 ref_en held", ref_en, 1'b1);
  endtask

  task automatic t_coincident;
    int_clk_mode = 1'b1;
    data_valid = 1'b1;
    clocks(1);
    frames(1995, 1'b1);
    frames(4, 1'b0);
    chk("R5 unmute after 1999 frames", unmute, 1'b0);
    chk("R6 deemph_en after 4 low edges", deemph_en, 1'b0);
    frames(1, 1'b0);
    chk("R5 unmute after 2000 frames", unmute, 1'b1);
    chk("R6 deemph_en after 5 low edges", deemph_en, 1'b1);
  endtask

  task automatic t_dv_drop;
    data_valid = 1'b0;
    clocks(2);
    chk("R5 unmute after data_valid drop", unmute, 1'b0);
    data_valid = 1'b1;
    frames(10, 1'b0);
    chk("R5 count restarted", unmute, 1'b0);
  endtask

  task automatic t_deemph_off;
    frames(4, 1'b1);
    chk("R6 deemph_en after 4 high edges", deemph_en, 1'b1);
    frames(1, 1'b1);
    chk("R6 deemph_en after 5 high edges", deemph_en, 1'b0);
  endtask

  task automatic t_restart;
    frames(3, 1'b0);
    frames(1, 1'b1);
    frames(4, 1'b0);
    chk("R7 restarted count not yet done", deemph_en, 1'b0);
    frames(1, 1'b0);
    chk("R7 restarted count reaches 5", deemph_en, 1'b1);
  endtask

  task automatic t_external;
    int_clk_mode = 1'b0;
    clocks(2);
    chk("R8 deemph_en cleared in external mode", deemph_en, 1'b0);
    frames(6, 1'b0);
    chk("R8 pin ignored in external mode", deemph_en, 1'b0);
  endtask

  task automatic t_mclk_loss;
    int_clk_mode = 1'b1;
    frames(5, 1'b0);
    chk("R9 setup deemph_en", deemph_en, 1'b1);
    mclk_present = 1'b0;
    clocks(1);
    chk("R9 core_rst after mclk loss", core_rst, 1'b1);
    chk("R9 enables after mclk loss", ref_en | conv_en | ramp_en | unmute | deemph_en, 1'b0);
  endtask

  initial begin
    clocks(3);
    t_reset();
    rst_n = 1'b1;
    clocks(2);
    t_reset();
    t_wait_clocks();
    t_measure();
    t_coincident();
    t_dv_drop();
    t_deemph_off();
    t_restart();
    t_external();
    t_mclk_loss();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule